// File: doc/BRIEF.md
# Serial Port Front End with Pin-Triggered Reset and Startup Sequencer

This block is the serial front end of a sensor. It acts as an SPI slave on four pins, serial clock, active-low select, data in and data out, and it runs entirely in the system clock domain. Clock, select and data in each pass through a two-flop synchronizer. Edges of the serial clock are detected on the synchronized copies. Each frame is 16 bits, most significant bit first. The block takes data in on rising serial clock edges and changes data out on falling edges.

The same two control pins also act as a hardware reset trigger. If select stays low while the serial clock stays high for a set hold time, the block issues a one-cycle internal reset pulse. After that pulse, or after the power-on reset, the block runs a startup sequence. Data out first floats for a set time. It is then driven high for a settle period. Only after that does the block raise ready and accept transfers again.

The first complete frame read after any reset carries a sticky flag in its top bit, so the host can notice resets it did not expect. All three times are given in microseconds and converted to clock counts from a clock frequency parameter.

Top module: `spi_rst_seq`

## Requirements
- R1: While ready, each frame of 16 rising serial clock edges after a select fall shifts data in MSB first. The assembled word appears on `rx_word_o` together with a one-cycle `rx_valid_o` pulse.
- R2: While ready, `miso_oe_o` is 1 exactly when select is low and 0 when select is high.
- R3: The response frame is {reset flag, `tx_payload_i[14:0]`}, with `tx_payload_i` captured at the select fall. Bit 15 is sent first, and each following bit appears after a falling serial clock edge.
- R4: Select held low with the serial clock held high for HOLD_US produces a single one-cycle `rst_pulse_o`. It also restarts the startup sequence and drops `ready_o`.
- R5: If select goes high or the serial clock goes low before HOLD_US has elapsed, no reset occurs. The hold timer then starts again from zero.
- R6: After any reset, `miso_oe_o` stays 0 for FLOAT_US.
- R7: After the float time, `miso_oe_o` is 1 and `miso_o` is 1 for SETTLE_US, whatever select does, and `ready_o` stays 0.
- R8: `ready_o` rises once the settle period ends.
- R9: Every reset sets the flag. Only a complete 16-bit frame taken while ready clears it. A frame cut short leaves it set.
- R10: Transfers made while not ready produce no `rx_valid_o` and leave the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sclk_i | input | 1 | Serial clock pin |
| cs_n_i | input | 1 | Active-low select pin |
| mosi_i | input | 1 | Serial data in |
| tx_payload_i | input | 15 | Low 15 bits of the response frame |
| miso_o | output | 1 | Serial data out value |
| miso_oe_o | output | 1 | Output enable for data out (0 means high impedance) |
| ready_o | output | 1 | Startup sequence finished |
| rst_pulse_o | output | 1 | One-cycle pulse on a pin-triggered reset |
| rx_word_o | output | 16 | Last complete received frame |
| rx_valid_o | output | 1 | One-cycle pulse when `rx_word_o` updates |

## Verification
The hardest condition to reach from the ports is a select-low, clock-high hold that stops just short of the reset threshold. A close second is a hold that is broken by a brief clock-low blip and then resumed. The stimulus holds the pins for the threshold minus a margin, with and without the blip, and then checks that ready never drops. The settle window is also exercised by starting a full transfer inside it. The following ready frame must still report the reset flag, and no receive pulse may appear.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [1:0] {
    SEQ_FLOAT  = 2'd0,
    SEQ_SETTLE = 2'd1,
    SEQ_READY  = 2'd2
  } seq_state_t;

  localparam int FRAME_W = 16;

  // microseconds -> clock cycles for a clock given in kHz
  function automatic int us2cyc(input int khz, input int us);
    return (khz * us) / 1000;
  endfunction

  // response frame layout: flag on top, payload below
  function automatic logic [FRAME_W-1:0] frame_word(input logic flag,
                                                   input logic [FRAME_W-2:0] payload);
    return {flag, payload};
  endfunction
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage1[i] <= RST_VAL[i];
          q[i]      <= RST_VAL[i];
        end else begin
          stage1[i] <= d[i];
          q[i]      <= stage1[i];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/srs_hold_det.sv
module srs_hold_det #(
  parameter int HOLD_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_s,
  input  logic sclk_s,
  output logic fire_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYC);

  logic [CW-1:0] cnt;
  logic          hold_cond;

  assign hold_cond = !cs_s && sclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      fire_o <= 1'b0;
    end else begin
      fire_o <= hold_cond && (cnt == LIMIT - 1'b1);
      if (!hold_cond)
        cnt <= '0;
      else if (cnt != LIMIT)
        cnt <= cnt + 1'b1;
    end
  end

  AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o); // R4
  AST_FIRE_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> $past(!cs_s && sclk_s)); // R5
endmodule

// File: rtl/srs_startup.sv
module srs_startup
  import srs_pkg::*;
#(
  parameter int FLOAT_CYC  = 1000,
  parameter int SETTLE_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic float_o,
  output logic drive_hi_o,
  output logic ready_o
);
  localparam int MAXC = (FLOAT_CYC > SETTLE_CYC) ? FLOAT_CYC : SETTLE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] FLOAT_END  = CW'(FLOAT_CYC - 1);
  localparam logic [CW-1:0] SETTLE_END = CW'(SETTLE_CYC - 1);

  seq_state_t    state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_FLOAT;
      cnt   <= '0;
    end else if (restart_i) begin
      state <= SEQ_FLOAT;
      cnt   <= '0;
    end else begin
      case (state)
        SEQ_FLOAT: begin
          if (cnt == FLOAT_END) begin
            state <= SEQ_SETTLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        SEQ_SETTLE: begin
          if (cnt == SETTLE_END) begin
            state <= SEQ_READY;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          state <= SEQ_READY;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign float_o    = (state == SEQ_FLOAT);
  assign drive_hi_o = (state == SEQ_SETTLE);
  assign ready_o    = (state == SEQ_READY);

  AST_RESTART_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> float_o); // R4
  AST_READY_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_hi_o && cnt == SETTLE_END && !restart_i) |=> ready_o); // R8
  AST_SETTLE_FROM_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_hi_o) |-> $past(float_o)); // R7
endmodule

// File: rtl/srs_shift.sv
module srs_shift
  import srs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart_i,
  input  logic               ready_i,
  input  logic               cs_fall_i,
  input  logic               cs_rise_i,
  input  logic               sclk_rise_i,
  input  logic               sclk_fall_i,
  input  logic               mosi_s,
  input  logic [FRAME_W-2:0] payload_i,
  output logic               tx_bit_o,
  output logic [FRAME_W-1:0] rx_word_o,
  output logic               rx_valid_o,
  output logic               flag_o
);
  localparam int BW = $clog2(FRAME_W + 1);
  localparam logic [BW-1:0] LAST = BW'(FRAME_W - 1);
  localparam logic [BW-1:0] FULL = BW'(FRAME_W);

  logic               active;
  logic [BW-1:0]      bitcnt;
  logic [FRAME_W-1:0] tx_sh;
  logic [FRAME_W-1:0] rx_sh;
  logic               frame_done;

  assign frame_done = active && sclk_rise_i && (bitcnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      bitcnt     <= '0;
      tx_sh      <= '1;
      rx_sh      <= '0;
      rx_word_o  <= '0;
      rx_valid_o <= 1'b0;
      flag_o     <= 1'b1;
    end else begin
      rx_valid_o <= 1'b0;
      if (restart_i) begin
        active <= 1'b0;
        flag_o <= 1'b1;
      end else if (cs_fall_i && ready_i) begin
        active <= 1'b1;
        bitcnt <= '0;
        tx_sh  <= frame_word(flag_o, payload_i);
      end else if (cs_rise_i || !ready_i) begin
        active <= 1'b0;
      end else if (active) begin
        if (sclk_rise_i && bitcnt != FULL) begin
          rx_sh  <= {rx_sh[FRAME_W-2:0], mosi_s};
          bitcnt <= bitcnt + 1'b1;
        end
        if (frame_done) begin
          rx_word_o  <= {rx_sh[FRAME_W-2:0], mosi_s};
          rx_valid_o <= 1'b1;
          flag_o     <= 1'b0;
        end
        if (sclk_fall_i)
          tx_sh <= {tx_sh[FRAME_W-2:0], 1'b1};
      end
    end
  end

  assign tx_bit_o = tx_sh[FRAME_W-1];

  AST_RX_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> $past(ready_i)); // R10
  AST_FLAG_ON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> flag_o); // R9
  AST_RX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o); // R1
endmodule

// File: rtl/spi_rst_seq.sv
module spi_rst_seq
  import srs_pkg::*;
#(
  parameter int CLK_KHZ   = 50000,
  parameter int HOLD_US   = 512,
  parameter int FLOAT_US  = 800,
  parameter int SETTLE_US = 3000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk_i,
  input  logic        cs_n_i,
  input  logic        mosi_i,
  input  logic [14:0] tx_payload_i,
  output logic        miso_o,
  output logic        miso_oe_o,
  output logic        ready_o,
  output logic        rst_pulse_o,
  output logic [15:0] rx_word_o,
  output logic        rx_valid_o
);
  localparam int HOLD_CYC   = us2cyc(CLK_KHZ, HOLD_US);
  localparam int FLOAT_CYC  = us2cyc(CLK_KHZ, FLOAT_US);
  localparam int SETTLE_CYC = us2cyc(CLK_KHZ, SETTLE_US);

  logic [2:0] pins_s;
  logic sclk_s, cs_s, mosi_s;
  logic sclk_q, cs_q;
  logic sclk_rise, sclk_fall, cs_rise, cs_fall;
  logic hold_fire, seq_float, seq_drive_hi, seq_ready, tx_bit, flag;

  srs_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({mosi_i, cs_n_i, sclk_i}), .q(pins_s)
  );
  assign sclk_s = pins_s[0];
  assign cs_s   = pins_s[1];
  assign mosi_s = pins_s[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_s;
    end
  end

  assign sclk_rise = sclk_s && !sclk_q;
  assign sclk_fall = !sclk_s && sclk_q;
  assign cs_rise   = cs_s && !cs_q;
  assign cs_fall   = !cs_s && cs_q;

  srs_hold_det #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sclk_s(sclk_s), .fire_o(hold_fire)
  );

  srs_startup #(.FLOAT_CYC(FLOAT_CYC), .SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .restart_i(hold_fire),
    .float_o(seq_float), .drive_hi_o(seq_drive_hi), .ready_o(seq_ready)
  );

  srs_shift u_shift (
    .clk(clk), .rst_n(rst_n), .restart_i(hold_fire), .ready_i(seq_ready),
    .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
    .mosi_s(mosi_s), .payload_i(tx_payload_i),
    .tx_bit_o(tx_bit), .rx_word_o(rx_word_o), .rx_valid_o(rx_valid_o),
    .flag_o(flag)
  );

  assign miso_oe_o   = seq_drive_hi || (seq_ready && !cs_s);
  assign miso_o      = seq_drive_hi ? 1'b1 : tx_bit;
  assign ready_o     = seq_ready;
  assign rst_pulse_o = hold_fire;

  AST_FLOAT_HIGHZ: assert property (@(posedge clk) disable iff (!rst_n)
    seq_float |-> !miso_oe_o); // R6
  AST_DESELECT_HIGHZ: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && cs_s) |-> !miso_oe_o); // R2
  AST_SETTLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe_o && !ready_o) |-> miso_o); // R7
  AST_PULSE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse_o |=> !ready_o); // R4
  AST_FLAG_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(flag)); // R9
endmodule

// File: tb/spi_rst_seq_bench.sv
module spi_rst_seq_bench;
  localparam int KHZ = 1000, HOLD_US = 512, FLOAT_US = 800, SETTLE_US = 3000;
  localparam int HOLD = KHZ * HOLD_US / 1000;
  localparam int FLT  = KHZ * FLOAT_US / 1000;
  localparam int SET  = KHZ * SETTLE_US / 1000;
  localparam int HALF = 8;

  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, mosi = 0;
  logic [14:0] payload = '0;
  logic miso, miso_oe, ready, rst_pulse, rx_valid;
  logic [15:0] rx_word;

  int checks = 0, fails = 0, cyc = 0, nvalid = 0, npulse = 0, last_pulse = 0;
  logic exp_flag = 1'b1;

  always #10 clk = ~clk;

  spi_rst_seq #(.CLK_KHZ(KHZ), .HOLD_US(HOLD_US), .FLOAT_US(FLOAT_US),
                .SETTLE_US(SETTLE_US)) u_spi_rst_seq (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .mosi_i(mosi),
    .tx_payload_i(payload), .miso_o(miso), .miso_oe_o(miso_oe), .ready_o(ready),
    .rst_pulse_o(rst_pulse), .rx_word_o(rx_word), .rx_valid_o(rx_valid)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (rx_valid) nvalid <= nvalid + 1;
    if (rst_pulse) begin npulse <= npulse + 1; last_pulse <= cyc; end
  end

  function automatic logic [15:0] exp_frame(input logic f, input logic [14:0] p);
    return {f, p};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // full or partial frame; returns bits seen on data out
  task automatic xfer(input logic [15:0] mo, input int nbits, output logic [15:0] mi);
    mi = '0;
    @(negedge clk); cs_n = 0;
    for (int i = 15; i > 15 - nbits; i--) begin
      mosi = mo[i];
      tick(HALF);
      mi[i] = miso;
      sclk = 1;
      tick(HALF);
      sclk = 0;
    end
    tick(HALF); cs_n = 1; tick(2 * HALF);
  endtask

  task automatic check_sequence(input int t0, input string tag);
    wait_to(t0 + FLT - 6);
    chk(!miso_oe, "R6 float", miso_oe, 0);
    wait_to(t0 + FLT + 8);
    chk(miso_oe && miso, "R7 drive high", {miso_oe, miso}, 2'b11);
    chk(!ready, "R7 not ready", ready, 0);
    wait_to(t0 + FLT + SET - 6);
    chk(!ready, "R8 ready late", ready, 0);
    wait_to(t0 + FLT + SET + 8);
    chk(ready, {"R8 ready ", tag}, ready, 1);
  endtask

  task automatic full_frame(input logic [15:0] mo, input string tag);
    logic [15:0] mi;
    int v0;
    v0 = nvalid;
    xfer(mo, 16, mi);
    chk(mi == exp_frame(exp_flag, payload), {"R3 R9 response ", tag}, mi,
        exp_frame(exp_flag, payload));
    chk(rx_word == mo && nvalid == v0 + 1, {"R1 rx ", tag}, rx_word, mo);
    exp_flag = 1'b0;
  endtask

  initial begin : wd
    wait (cyc > 190000);
    chk(0, "watchdog", cyc, 190000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [15:0] mi;
    int v0, p0, t0;
    void'($urandom(32'd2024));
    tick(5);
    chk(!ready && !miso_oe, "R6 reset state", {ready, miso_oe}, 0);
    @(negedge clk); rst_n = 1; t0 = cyc;
    wait_to(t0 + FLT - 6);
    chk(!miso_oe, "R6 power-on float", miso_oe, 0);
    wait_to(t0 + FLT + 8);
    chk(miso_oe && miso, "R7 power-on high", {miso_oe, miso}, 2'b11);
    // R10: transfer inside settle window is ignored
    v0 = nvalid;
    xfer(16'hA5C3, 16, mi);
    chk(nvalid == v0, "R10 no rx in settle", nvalid, v0);
    chk(mi == 16'hFFFF, "R7 settle reads high", mi, 16'hFFFF);
    wait_to(t0 + FLT + SET + 8);
    chk(ready, "R8 power-on ready", ready, 1);
    // R2
    chk(!miso_oe, "R2 deselected highz", miso_oe, 0);
    @(negedge clk); cs_n = 0; tick(6);
    chk(miso_oe, "R2 selected drives", miso_oe, 1);
    cs_n = 1; tick(6);
    payload = 15'h1234;
    full_frame(16'h3C5A, "first");
    full_frame(16'h8001, "second");
    // R5: short holds, including one broken by a clock-low blip
    p0 = npulse;
    @(negedge clk); cs_n = 0; sclk = 1; tick(HOLD - 20);
    sclk = 0; tick(3); sclk = 1; tick(HOLD - 20);
    sclk = 0; tick(3); cs_n = 1; tick(3); cs_n = 0; sclk = 1; tick(HOLD - 20);
    sclk = 0; tick(HALF); cs_n = 1; tick(20);
    chk(npulse == p0 && ready, "R5 short hold no reset", {npulse[30:0], ready},
        {p0[30:0], 1'b1});
    full_frame(16'h0F0F, "after short hold");
    // R4: long hold
    @(negedge clk); cs_n = 0; sclk = 1; tick(HOLD + 20);
    chk(npulse == p0 + 1, "R4 one pulse", npulse, p0 + 1);
    t0 = last_pulse;
    sclk = 0; tick(2); cs_n = 1; exp_flag = 1'b1;
    check_sequence(t0, "hw");
    // R9: partial frame keeps the flag
    xfer(16'hFFFF, 8, mi);
    chk(mi[15] == 1'b1, "R9 partial frame flag", mi[15], 1);
    full_frame(16'h1357, "after partial");
    // random traffic
    for (int k = 0; k < 24; k++) begin
      payload = 15'($urandom);
      full_frame(16'($urandom), "random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule